// File: doc/BRIEF.md
# Wide-Screen Raster Timing Generator

This block produces the scan timing for a 1680x1050 monitor refreshed at roughly 60 Hz. It is clocked by one pixel clock of about 147 MHz, which is generated elsewhere. The nominal rate is 2256 x 1087 x 60, or about 147.14 MHz. A clock that runs a little faster only raises the refresh rate slightly.

Inside the block, a column counter steps through each scan line and a row counter steps through each frame. Both counters are decoded into five registered outputs: a horizontal sync, a vertical sync, a visible-area flag and the current column and row. Drawing logic downstream uses the column, the row and the flag to pick a colour for each pixel.

The two syncs have opposite resting levels. The horizontal sync rests high and pulses low. The vertical sync rests low and pulses high. A synchronous reset sends the scan back to the top-left pixel.

Top module: `raster_timing`

## Requirements
- R1: The column output counts up by one per clock from 0 to 2255 and then returns to 0. A line is therefore 2256 clocks long: 1680 visible columns, then 104 front-porch clocks, 184 sync clocks and 288 back-porch clocks.
- R2: The row output changes only on the clock where the column goes from 2255 to 0. On that clock it goes up by one, or from 1086 back to 0. A frame is 1087 rows: 1050 visible, then 1 front-porch row, 3 sync rows and 33 back-porch rows.
- R3: `hsync_o` is low exactly while the column is in the range 1784 to 1967, and high otherwise.
- R4: `vsync_o` is high exactly while the row is in the range 1051 to 1053, and low otherwise.
- R5: `visible_o` is high exactly when the column is below 1680 and the row is below 1050.
- R6: All outputs come from registers and refer to the same pixel. On the first clock edge that samples reset low, the outputs show column 0, row 0 with `visible_o` high. Each later edge shows the next pixel.
- R7: Each edge that samples `rst` high sets the outputs to rest values: `hsync_o` high, `vsync_o` low, `visible_o` low, column 0 and row 0. Scanning then starts again from column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_o | output | 1 | Horizontal sync, resting high, low during line sync |
| vsync_o | output | 1 | Vertical sync, resting low, high during frame sync |
| visible_o | output | 1 | High while the pixel lies in the visible area |
| col_o | output | 12 | Current column within the line |
| row_o | output | 11 | Current row within the frame |

## Verification
The assertions assume that `rst` is a clean synchronous level and that no other input exists to disturb the scan. They also assume that once reset drops, the counters run free. The stepping and row-hold checks are gated by a flag that marks the first pixel after reset. This keeps them from treating the reset-to-first-pixel transition as a scan step.

The stimulus changes `rst` only on falling edges. A default-size instance checks the line timing over several lines. A shrunken instance checks vertical sync, row wrap and full frames within the cycle budget. A reset pulse in mid-frame exercises the restart path of both instances.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int H_VIS   = 1680,
  parameter int H_FRONT = 104,
  parameter int H_SYNC  = 184,
  parameter int H_BACK  = 288,
  parameter int V_VIS   = 1050,
  parameter int V_FRONT = 1,
  parameter int V_SYNC  = 3,
  parameter int V_BACK  = 33,
  localparam int H_TOT  = H_VIS + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOT  = V_VIS + V_FRONT + V_SYNC + V_BACK,
  localparam int XW     = $clog2(H_TOT),
  localparam int YW     = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          visible_o,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o
);

  localparam logic [XW-1:0] H_LAST = XW'(H_TOT - 1);
  localparam logic [YW-1:0] V_LAST = YW'(V_TOT - 1);
  localparam logic [XW-1:0] H_VEND = XW'(H_VIS);
  localparam logic [YW-1:0] V_VEND = YW'(V_VIS);
  localparam logic [XW-1:0] HS_BEG = XW'(H_VIS + H_FRONT);
  localparam logic [XW-1:0] HS_END = XW'(H_VIS + H_FRONT + H_SYNC);
  localparam logic [YW-1:0] VS_BEG = YW'(V_VIS + V_FRONT);
  localparam logic [YW-1:0] VS_END = YW'(V_VIS + V_FRONT + V_SYNC);

  logic [XW-1:0] hcnt;
  logic [YW-1:0] vcnt;
  logic          line_end;
  logic          frame_end;
  logic          started;

  assign line_end  = (hcnt == H_LAST);
  assign frame_end = (vcnt == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end)
        vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o   <= 1'b1;
      vsync_o   <= 1'b0;
      visible_o <= 1'b0;
      col_o     <= '0;
      row_o     <= '0;
      started   <= 1'b0;
    end else begin
      hsync_o   <= !(hcnt >= HS_BEG && hcnt < HS_END);
      vsync_o   <= (vcnt >= VS_BEG && vcnt < VS_END);
      visible_o <= (hcnt < H_VEND) && (vcnt < V_VEND);
      col_o     <= hcnt;
      row_o     <= vcnt;
      started   <= 1'b1;
    end
  end

  assert_col_step_R1: assert property (@(posedge clk) disable iff (rst)
    (started && col_o != H_LAST) |=> (col_o == $past(col_o) + 1'b1));

  assert_col_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (started && col_o == H_LAST) |=> (col_o == '0));

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (started && col_o != H_LAST) |=> $stable(row_o));

  assert_row_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (started && col_o == H_LAST && row_o == V_LAST) |=> (row_o == '0));

  assert_hsync_window_R3: assert property (@(posedge clk) disable iff (rst)
    started |-> (hsync_o == !(col_o >= HS_BEG && col_o < HS_END)));

  assert_vsync_window_R4: assert property (@(posedge clk) disable iff (rst)
    started |-> (vsync_o == (row_o >= VS_BEG && row_o < VS_END)));

  assert_visible_area_R5: assert property (@(posedge clk) disable iff (rst)
    visible_o |-> (col_o < H_VEND && row_o < V_VEND));

  assert_first_pixel_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(started) |-> (col_o == '0 && row_o == '0 && visible_o));

  assert_reset_rest_R7: assert property (@(posedge clk)
    rst |=> (hsync_o && !vsync_o && !visible_o && col_o == '0 && row_o == '0));

endmodule

// File: tb/raster_timing_tb_top.sv
module raster_timing_tb_top;

  typedef struct {
    int hs;
    int vs;
    int vis;
    int x;
    int y;
    int kind;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  item_t qa[$];
  item_t qb[$];

  logic        a_hs, a_vs, a_vis;
  logic [11:0] a_x;
  logic [10:0] a_y;
  logic        b_hs, b_vs, b_vis;
  logic [3:0]  b_x;
  logic [3:0]  b_y;

  raster_timing dut_i (
    .clk(clk), .rst(rst), .hsync_o(a_hs), .vsync_o(a_vs),
    .visible_o(a_vis), .col_o(a_x), .row_o(a_y)
  );

  raster_timing #(
    .H_VIS(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(3),
    .V_VIS(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(2)
  ) small_i (
    .clk(clk), .rst(rst), .hsync_o(b_hs), .vsync_o(b_vs),
    .visible_o(b_vis), .col_o(b_x), .row_o(b_y)
  );

  function automatic item_t expect_at(int p, int ha, int hf, int hsw, int hb,
                                      int va, int vf, int vsw, int vb);
    item_t it;
    int ht = ha + hf + hsw + hb;
    it.x    = p % ht;
    it.y    = p / ht;
    it.hs   = (it.x >= ha + hf && it.x < ha + hf + hsw) ? 0 : 1;
    it.vs   = (it.y >= va + vf && it.y < va + vf + vsw) ? 1 : 0;
    it.vis  = (it.x < ha && it.y < va) ? 1 : 0;
    it.kind = 0;
    return it;
  endfunction

  function automatic item_t rest_item();
    item_t it;
    it.hs = 1; it.vs = 0; it.vis = 0; it.x = 0; it.y = 0; it.kind = 1;
    return it;
  endfunction

  int pa = 0;
  int pb = 0;

  task automatic drive_expect();
    item_t ia;
    item_t ib;
    if (rst) begin
      ia = rest_item();
      ib = rest_item();
      pa = 0;
      pb = 0;
    end else begin
      ia = expect_at(pa, 1680, 104, 184, 288, 1050, 1, 3, 33);
      ib = expect_at(pb, 8, 2, 3, 3, 4, 1, 2, 2);
      if (pa == 0) ia.kind = 2;
      if (pb == 0) ib.kind = 2;
      pa = (pa + 1) % (2256 * 1087);
      pb = (pb + 1) % (16 * 9);
    end
    #1;
    qa.push_back(ia);
    qb.push_back(ib);
  endtask

  always @(posedge clk) drive_expect();

  task automatic chk(string tag, string name, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, name, got, exp, $time);
    end
  endtask

  function automatic string tag_of(item_t e, string normal);
    if (e.kind == 1) return "R7";
    if (e.kind == 2) return "R6";
    return normal;
  endfunction

  always @(negedge clk) begin
    item_t e;
    if (qa.size() > 0) begin
      e = qa.pop_front();
      chk(tag_of(e, "R1"), "big col", int'(a_x), e.x);
      chk(tag_of(e, "R2"), "big row", int'(a_y), e.y);
      chk(tag_of(e, "R3"), "big hsync", int'(a_hs), e.hs);
      chk(tag_of(e, "R4"), "big vsync", int'(a_vs), e.vs);
      chk(tag_of(e, "R5"), "big visible", int'(a_vis), e.vis);
    end
    if (qb.size() > 0) begin
      e = qb.pop_front();
      chk(tag_of(e, "R1"), "small col", int'(b_x), e.x);
      chk(tag_of(e, "R2"), "small row", int'(b_y), e.y);
      chk(tag_of(e, "R3"), "small hsync", int'(b_hs), e.hs);
      chk(tag_of(e, "R4"), "small vsync", int'(b_vs), e.vs);
      chk(tag_of(e, "R5"), "small visible", int'(b_vis), e.vis);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (5000) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2400) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule